// File: doc/BRIEF.md
# Fast Link Pulse Burst Generator

This block serializes a link code word into a timed train of narrow pulses on one digital line, as used when two link partners exchange configuration before a link comes up. Each burst interleaves framing clock pulses, which are always sent, with data slots in which a pulse appears only for a 1 bit. Bursts repeat at a fixed period for as long as transmission is enabled. Analog pulse shaping and the line driver sit downstream and are not part of this block.

All timing runs on an external timebase strobe `tick`. The pulse width, the clock-to-clock spacing, the clock-to-data offset and the burst repeat period are parameters counted in ticks. The word arrives on a valid/ready interface. `word_ready` is high only on a tick on which a burst may begin. A word is taken on the cycle where `word_valid` and `word_ready` are both high, and that transfer is what starts a burst. If no word is valid when a burst could start, the generator waits and the line stays low. A source that holds `word_valid` may not change `word_in` until the transfer. After the transfer, `word_in` may change freely. Software-visible state and the line interface are out of scope.

Top module: `flp_burst_gen`

## Requirements
- R1: During and after reset with `enable` low, `flp_out`, `burst_done` and `word_ready` are all 0.
- R2: A burst has DATA_BITS+1 clock pulses (17 by default), position 0 always a clock. Clock pulse k rises CLK_GAP*k ticks after the first one.
- R3: Data bit k is sent least-significant bit first, in the slot DATA_OFS ticks after clock pulse k. A 1 puts a pulse in the slot and a 0 leaves the slot empty, so a burst holds 17 pulses plus the number of 1 bits.
- R4: Every pulse stays high for exactly PULSE_W ticks. Outputs change only after a cycle in which `tick` was high.
- R5: `word_ready` is high only on a cycle with `tick` and `enable` high, while idle or at the end of a repeat period. The word is captured at the transfer, and later changes on `word_in` do not alter the burst in progress.
- R6: While enabled with a word pending, a new burst starts exactly PERIOD ticks after the previous one.
- R7: `burst_done` is a one-cycle strobe on the tick that ends the final clock pulse. That tick is CLK_GAP*DATA_BITS+PULSE_W-1 ticks after the burst started, and the strobe comes once per burst.
- R8: Deasserting `enable` during a burst lets that burst complete. After it, no further burst starts and the line stays low until `enable` returns.
- R9: With `enable` high but no valid word, no pulse is sent and no burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe; all interval counters advance on it |
| enable | input | 1 | Allows new bursts to start |
| word_in | input | DATA_BITS | Code word to send |
| word_valid | input | 1 | `word_in` holds a word to send |
| word_ready | output | 1 | A burst may begin on this cycle |
| flp_out | output | 1 | Pulse train output |
| burst_done | output | 1 | Strobe on the final cycle of a burst |

## Verification
The end of a repeat period and a change of `enable` can fall on the same tick. The outcome then decides whether the pending word launches a burst or waits. The bench holds a word valid and drops `enable` on exactly the tick where the repeat period expires. It expects no transfer and no pulse, then expects the burst to start on the first tick after `enable` returns. In the same way, a word that is ready on the last period tick must produce a relaunch spaced exactly PERIOD ticks from the burst before it.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } flp_state_e;
endpackage

// File: rtl/flp_slot_timer.sv
// Walks the pulse positions of one burst. Even positions are clocks, odd ones are data.
module flp_slot_timer #(
  parameter int CLK_GAP  = 1250,
  parameter int DATA_OFS = 625,
  parameter int PULSE_W  = 1,
  parameter int POS_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             run,
  output logic [POS_W-1:0] pos,
  output logic             pulse_win,
  output logic             pulse_end
);
  localparam int CW = $clog2(CLK_GAP + 1);
  localparam logic [CW-1:0] LAST_EVEN = CW'(DATA_OFS - 1);
  localparam logic [CW-1:0] LAST_ODD  = CW'(CLK_GAP - DATA_OFS - 1);
  localparam logic [CW-1:0] WIDTH     = CW'(PULSE_W);

  logic [CW-1:0] scnt;
  logic [CW-1:0] slot_last;

  assign slot_last = pos[0] ? LAST_ODD : LAST_EVEN;
  assign pulse_win = scnt < WIDTH;
  assign pulse_end = scnt == WIDTH - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt <= '0;
      pos  <= '0;
    end else if (start) begin
      scnt <= '0;
      pos  <= '0;
    end else if (run && tick) begin
      if (scnt == slot_last) begin
        scnt <= '0;
        pos  <= pos + 1'b1;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flp_period_timer.sv
// Counts ticks from the start of a burst and flags the last tick of the repeat period.
module flp_period_timer #(
  parameter int PERIOD = 160000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic run,
  output logic period_end
);
  localparam int PW = $clog2(PERIOD + 1);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] pcnt;

  assign period_end = pcnt == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pcnt <= '0;
    else if (start)
      pcnt <= '0;
    else if (run && tick && !period_end)
      pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/flp_bit_select.sv
// Holds the captured word and decides whether the current position carries a pulse.
module flp_bit_select #(
  parameter int DATA_BITS = 16,
  parameter int POS_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] word_in,
  input  logic [POS_W-1:0]     pos,
  output logic                 slot_on
);
  localparam int IDX_W = POS_W - 1;
  localparam int IDX_N = 1 << IDX_W;

  logic [DATA_BITS-1:0] word_q;
  logic [IDX_N-1:0]     ext;
  logic [IDX_W-1:0]     idx;

  generate
    if (IDX_N > DATA_BITS) begin : g_pad
      assign ext = {{(IDX_N - DATA_BITS){1'b0}}, word_q};
    end else begin : g_fit
      assign ext = word_q[IDX_N-1:0];
    end
  endgenerate

  assign idx     = pos[POS_W-1:1];
  assign slot_on = !pos[0] || ext[idx];

  always_ff @(posedge clk) begin
    if (!rst_n)
      word_q <= '0;
    else if (load)
      word_q <= word_in;
  end
endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen #(
  parameter int DATA_BITS = 16,
  parameter int PULSE_W   = 1,
  parameter int DATA_OFS  = 625,
  parameter int CLK_GAP   = 1250,
  parameter int PERIOD    = 160000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 enable,
  input  logic [DATA_BITS-1:0] word_in,
  input  logic                 word_valid,
  output logic                 word_ready,
  output logic                 flp_out,
  output logic                 burst_done
);
  import flp_pkg::*;

  localparam int POSITIONS = 2 * DATA_BITS + 1;
  localparam int POS_W     = $clog2(POSITIONS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(POSITIONS - 1);

  flp_state_e       state;
  logic [POS_W-1:0] pos;
  logic             pulse_win, pulse_end, period_end, slot_on;
  logic             start, last_hit, in_burst;

  assign in_burst   = state == ST_BURST;
  assign word_ready = tick && enable &&
                      (state == ST_IDLE || (state == ST_GAP && period_end));
  assign start      = word_ready && word_valid;
  assign last_hit   = in_burst && tick && pos == LAST_POS && pulse_end;
  assign burst_done = last_hit;
  assign flp_out    = in_burst && pulse_win && slot_on;

  flp_slot_timer #(
    .CLK_GAP(CLK_GAP), .DATA_OFS(DATA_OFS), .PULSE_W(PULSE_W), .POS_W(POS_W)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .run(in_burst),
    .pos(pos), .pulse_win(pulse_win), .pulse_end(pulse_end)
  );

  flp_period_timer #(.PERIOD(PERIOD)) u_period (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .run(state != ST_IDLE), .period_end(period_end)
  );

  flp_bit_select #(.DATA_BITS(DATA_BITS), .POS_W(POS_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .load(start), .word_in(word_in),
    .pos(pos), .slot_on(slot_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (start) begin
      state <= ST_BURST;
    end else begin
      case (state)
        ST_BURST: if (last_hit) state <= ST_GAP;
        ST_GAP:   if (tick && period_end) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flp_burst_gen_chk.sv
module flp_burst_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic enable,
  input logic word_valid,
  input logic word_ready,
  input logic flp_out,
  input logic burst_done
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  a_r7_done_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> flp_out);

  a_r5_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> (tick && enable));

  a_r2_first_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> flp_out);

  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(flp_out));
endmodule

bind flp_burst_gen flp_burst_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
  .word_valid(word_valid), .word_ready(word_ready),
  .flp_out(flp_out), .burst_done(burst_done)
);

// File: tb/test_flp_burst_gen.sv
module test_flp_burst_gen;
  localparam int NB  = 16;
  localparam int PW  = 2;
  localparam int DOF = 5;
  localparam int CG  = 12;
  localparam int PER = 250;

  logic clk = 0, rst_n = 0, tick = 0, enable = 0, word_valid = 0;
  logic [NB-1:0] word_in = '0;
  logic word_ready, flp_out, burst_done;

  int errors = 0, checks = 0;
  int tc = 0, rise_tc = 0, rises = 0, cur_n = 0, hs_cnt = 0, done_cnt = 0;
  bit prev_out = 0, b2b_chk = 0;
  int exp_q[$];
  string tag_q[$];
  int n_q[$];

  flp_burst_gen #(.DATA_BITS(NB), .PULSE_W(PW), .DATA_OFS(DOF),
                  .CLK_GAP(CG), .PERIOD(PER)) i_flp_burst_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .word_in(word_in),
    .word_valid(word_valid), .word_ready(word_ready), .flp_out(flp_out),
    .burst_done(burst_done)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      #1 tick = ~tick;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected pulse start ticks and compares them as pulses appear
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_out = 0;
      tc = 0;
    end else begin
      if (flp_out && !prev_out) begin
        rises++;
        rise_tc = tc;
        if (exp_q.size() == 0) chk(0, "R8", "unexpected pulse at tick", tc, -1);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(tc == e, t, "pulse start tick", tc, e);
        end
      end
      if (!flp_out && prev_out)
        chk(tc - rise_tc == PW, "R4", "pulse width in ticks", tc - rise_tc, PW);
      if (burst_done) begin
        done_cnt++;
        chk(tick && tc == CG * NB + PW - 1, "R7", "burst_done tick", tc, CG * NB + PW - 1);
        chk(rises == cur_n, "R3", "pulses in burst", rises, cur_n);
      end
      if (tick && word_valid && word_ready) begin
        if (b2b_chk) chk(tc + 1 == PER, "R6", "relaunch spacing", tc + 1, PER);
        b2b_chk = 0;
        hs_cnt++;
        tc = 0;
        rises = 0;
        cur_n = (n_q.size() != 0) ? n_q.pop_front() : -1;
      end else if (tick) begin
        tc++;
      end
      prev_out = flp_out;
    end
  end

  // Driver: pushes the expected pulse starts for a word, then offers it
  task automatic queue_word(input logic [NB-1:0] w);
    int n = 0;
    for (int k = 0; k <= NB; k++) begin
      exp_q.push_back(k * CG); tag_q.push_back("R2"); n++;
      if (k < NB && w[k]) begin
        exp_q.push_back(k * CG + DOF); tag_q.push_back("R3"); n++;
      end
    end
    n_q.push_back(n);
    word_in = w;
    word_valid = 1;
  endtask

  task automatic wait_hs();
    int h = hs_cnt;
    while (hs_cnt == h) begin
      @(posedge clk);
      #2;
    end
    word_valid = 0;
    word_in = ~word_in;   // R5: later changes must not reach the burst
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        chk(0, "R6", "watchdog expired", wd, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int h;
    repeat (4) @(negedge clk);
    chk(!flp_out && !burst_done && !word_ready, "R1", "outputs in reset",
        {flp_out, burst_done, word_ready}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (6) @(negedge clk);
    chk(!flp_out && !burst_done && !word_ready, "R1", "outputs after reset",
        {flp_out, burst_done, word_ready}, 0);

    // R9: enabled with nothing valid
    @(posedge clk); #1 enable = 1;
    repeat (60) @(negedge clk);
    chk(hs_cnt == 0 && !flp_out, "R9", "no burst without valid word", hs_cnt, 0);

    @(posedge clk); #1;
    queue_word(16'hA5C3); wait_hs();
    b2b_chk = 1; queue_word(16'h0000); wait_hs();
    b2b_chk = 1; queue_word(16'hFFFF); wait_hs();

    // R8: drop enable a few pulses into the burst
    while (rises < 3) begin @(posedge clk); #2; end
    enable = 0;
    h = hs_cnt;
    queue_word(16'h1234);
    repeat (1100) @(negedge clk);
    chk(hs_cnt == h, "R8", "no launch while disabled", hs_cnt, h);
    chk(!flp_out, "R8", "line low while disabled", flp_out, 0);
    chk(done_cnt == 3, "R8", "disabled burst completed", done_cnt, 3);
    @(posedge clk); #1 enable = 1;
    wait_hs();

    // enable falls on exactly the period-end tick with a word pending
    queue_word(16'h0F0F);
    h = hs_cnt;
    do begin @(posedge clk); #2; end while (!(tick && tc == PER - 1 && hs_cnt == h));
    enable = 0;
    repeat (20) @(negedge clk);
    chk(hs_cnt == h, "R5", "period-end tick with enable low launched", hs_cnt, h);
    chk(!word_ready, "R5", "ready while disabled", word_ready, 0);
    @(posedge clk); #1 enable = 1;
    wait_hs();
    chk(hs_cnt == h + 1, "R5", "launch after re-enable", hs_cnt, h + 1);
    wait_done(5);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "expected pulses left", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule